// File: doc/BRIEF.md
# Block-Streaming MAC Protocol Sequencer

This block is the control half of a streaming dot-product engine. Two 8-bit buses deliver a fixed-length block on every enabled clock. The first cycle carries two mode bytes. The next two cycles optionally carry a scale and a format descriptor for each operand. Then come the element pairs. The sequencer counts these cycles, stores the configuration for the arithmetic datapath and tells the datapath when to clear, accumulate and finish. It then returns the datapath's 32-bit sum one byte per cycle on a single 8-bit output bus.

Two shortcuts shorten a block. A reuse flag in the first mode byte skips both configuration cycles and keeps the stored scales and formats. A packing flag in the second mode byte, when both stored formats are the 4-bit E2M1 code, halves the element phase: each cycle then carries two elements per operand on two lanes. With both shortcuts a block takes 23 enabled cycles instead of 41. A debug flag routes one of eleven internal probe bytes to the output bus during the configuration and element cycles, and echoes the first mode byte during the flush cycle.

Top module: `mxblk_seq`

## Requirements
- R1: A standard block takes 41 enabled cycles: mode cycle 0, configuration cycles 1 and 2, element cycles 3 to 34, flush at 35, calculate at 36 and result bytes at 37 to 40.
- R2: When bit 7 of `bus_a` is set in cycle 0, the next enabled cycle is the first element cycle, and the scales and formats of the previous block remain unchanged.
- R3: When bit 6 of the stored second mode byte is set and both stored formats equal code 4 (E2M1), the element phase lasts 16 cycles. `lane1_en` is then high on every element cycle and `elem_idx` equals twice the element-cycle number. Otherwise the phase lasts 32 cycles, `lane1_en` is low and `elem_idx` equals the element-cycle number.
- R4: In cycle 1, `bus_a` is stored as scale A, `bus_b[2:0]` as format A and `bus_b[7:3]` as block-max index A. Cycle 2 does the same for operand B. The stored values stay on the outputs until the next such cycle.
- R5: `acc_en` is high on every enabled element cycle. `acc_clr` is high only on the enabled first element cycle of a block.
- R6: `calc_go` is high on the enabled calculate cycle, and `acc_in` is captured at that cycle. Over cycles 37 to 40 the captured value appears on `out_byte`, least-significant byte first.
- R7: With debug off (bit 6 of the stored first mode byte clear), `out_byte` is 0x00 in every cycle other than 37 to 40. In cycle 0 it is always 0x00.
- R8: With debug on, `out_byte` carries a probe in cycles 1 to 34 and the first mode byte at flush; cycle 36 stays 0x00. The selector is the stored `bus_b[3:0]`: 0 phase code in bits [2:0] (0 mode, 1 config A, 2 config B, 3 elements, 4 flush, 5 calc, 6 output), 1 `exc_in`, 2 to 5 `acc_in` bytes 0 to 3, 6/7 `prod0` low/high, 8/9 `prod1` low/high, 10 {`en`,`lane1_en`,`acc_en`,`acc_clr`,0000}, other values 0x00.
- R9: While `en` is low the sequence position and all stored values hold, bus contents are ignored, and `acc_en`, `acc_clr` and `calc_go` are low.
- R10: A high `rst` at a clock edge returns the block to cycle 0 and clears the mode bytes, scales, formats, indices and captured result to zero.
- R11: After cycle 40 the next enabled cycle is a new cycle 0, with no idle cycle between blocks.
- R12: The two cycle-0 bytes are presented on `mode_a` and `mode_b` from the following cycle until the next cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| bus_a | input | 8 | Mode byte / scale A / element A |
| bus_b | input | 8 | Mode byte / format+index / element B |
| acc_in | input | 32 | Datapath accumulator value |
| prod0 | input | 16 | Lane 0 product |
| prod1 | input | 16 | Lane 1 product |
| exc_in | input | 8 | Datapath exception flags |
| out_byte | output | 8 | Result byte, probe or zero |
| mode_a | output | 8 | Stored first mode byte |
| mode_b | output | 8 | Stored second mode byte |
| scale_a | output | 8 | Stored scale A |
| scale_b | output | 8 | Stored scale B |
| fmt_a | output | 3 | Stored format A |
| fmt_b | output | 3 | Stored format B |
| bmi_a | output | 5 | Stored block-max index A |
| bmi_b | output | 5 | Stored block-max index B |
| elem_idx | output | 5 | Index of the lane 0 element |
| lane1_en | output | 1 | Second lane active |
| acc_clr | output | 1 | Clear accumulator |
| acc_en | output | 1 | Accumulate this cycle |
| calc_go | output | 1 | Finalize sum this cycle |

## Verification
The hardest case to reach is the combined shortcut. The packed 16-cycle phase depends on formats stored by an earlier block, while the reuse flag of the current block skips the very cycles that would set them. The stimulus therefore first runs a full block that loads E2M1 for both operands. Only then does it issue reuse-plus-pack blocks, which also sweep every probe selector. A separate block holds the pack flag with mismatched formats, and another drops `en` at random points with junk on the buses. These two show that the length test and the enable gating each fall back correctly.

// File: rtl/mxseq_pkg.sv
package mxseq_pkg;

    localparam int BYTE_W = 8;
    localparam int FMT_W  = 3;
    localparam int BMI_W  = 5;
    localparam int SEL_W  = 4;

    // Mode byte bit positions
    localparam int MA_SHORT = 7;
    localparam int MA_DEBUG = 6;
    localparam int MB_PACK  = 6;

    typedef enum logic [2:0] {
        PH_META   = 3'd0,
        PH_CFGA   = 3'd1,
        PH_CFGB   = 3'd2,
        PH_STREAM = 3'd3,
        PH_FLUSH  = 3'd4,
        PH_CALC   = 3'd5,
        PH_OUT    = 3'd6
    } phase_e;

    typedef enum logic [FMT_W-1:0] {
        FMT_E4M3  = 3'd0,
        FMT_E5M2  = 3'd1,
        FMT_E3M2  = 3'd2,
        FMT_E2M3  = 3'd3,
        FMT_E2M1  = 3'd4,
        FMT_INT8  = 3'd5,
        FMT_INT8S = 3'd6,
        FMT_RSVD  = 3'd7
    } fmt_e;

    typedef enum logic [SEL_W-1:0] {
        PR_STATE = 4'd0,
        PR_EXC   = 4'd1,
        PR_ACC0  = 4'd2,
        PR_ACC1  = 4'd3,
        PR_ACC2  = 4'd4,
        PR_ACC3  = 4'd5,
        PR_P0L   = 4'd6,
        PR_P0H   = 4'd7,
        PR_P1L   = 4'd8,
        PR_P1H   = 4'd9,
        PR_CTRL  = 4'd10
    } probe_e;

    typedef struct packed {
        logic [BYTE_W-1:0] scale;
        fmt_e              fmt;
        logic [BMI_W-1:0]  bmi;
    } opcfg_t;

    localparam opcfg_t OPCFG_RST = '{scale: '0, fmt: FMT_E4M3, bmi: '0};

    function automatic opcfg_t decode_cfg(input logic [BYTE_W-1:0] sc,
                                          input logic [BYTE_W-1:0] fb);
        opcfg_t c;
        c.scale = sc;
        c.fmt   = fmt_e'(fb[FMT_W-1:0]);
        c.bmi   = fb[BYTE_W-1:FMT_W];
        return c;
    endfunction

    function automatic logic both_fp4(input opcfg_t a, input opcfg_t b);
        return (a.fmt == FMT_E2M1) && (b.fmt == FMT_E2M1);
    endfunction

endpackage

// File: rtl/mxseq_ctrl.sv
module mxseq_ctrl
    import mxseq_pkg::*;
#(
    parameter int N_ELEM    = 32,
    parameter int RES_BYTES = 4,
    parameter int CNT_W     = $clog2(N_ELEM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             short_req,
    input  logic             pack_now,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(N_ELEM - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(N_ELEM / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_OUT  = CNT_W'(RES_BYTES - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] stream_last;

    assign stream_last = pack_now ? LAST_HALF : LAST_FULL;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (en) begin
            unique case (phase_q)
                PH_META: begin
                    cnt_d   = '0;
                    phase_d = short_req ? PH_STREAM : PH_CFGA;
                end
                PH_CFGA: phase_d = PH_CFGB;
                PH_CFGB: begin
                    phase_d = PH_STREAM;
                    cnt_d   = '0;
                end
                PH_STREAM: begin
                    if (cnt_q == stream_last) begin
                        phase_d = PH_FLUSH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                PH_FLUSH: phase_d = PH_CALC;
                PH_CALC: begin
                    phase_d = PH_OUT;
                    cnt_d   = '0;
                end
                PH_OUT: begin
                    if (cnt_q == LAST_OUT) begin
                        phase_d = PH_META;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    phase_d = PH_META;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_META;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase = phase_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/mxseq_cfg.sv
module mxseq_cfg
    import mxseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  phase_e            phase,
    input  logic [BYTE_W-1:0] bus_a,
    input  logic [BYTE_W-1:0] bus_b,
    output logic [BYTE_W-1:0] mode_a,
    output logic [BYTE_W-1:0] mode_b,
    output opcfg_t            cfg_a,
    output opcfg_t            cfg_b,
    output logic              pack_now
);

    logic [BYTE_W-1:0] mode_a_q, mode_b_q;
    opcfg_t            cfg_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_a_q <= '0;
            mode_b_q <= '0;
        end else if (en && phase == PH_META) begin
            mode_a_q <= bus_a;
            mode_b_q <= bus_b;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_op
        localparam phase_e LOAD_PH = (g == 0) ? PH_CFGA : PH_CFGB;
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= OPCFG_RST;
            end else if (en && phase == LOAD_PH) begin
                cfg_q[g] <= decode_cfg(bus_a, bus_b);
            end
        end
    end

    assign mode_a   = mode_a_q;
    assign mode_b   = mode_b_q;
    assign cfg_a    = cfg_q[0];
    assign cfg_b    = cfg_q[1];
    assign pack_now = mode_b_q[MB_PACK] && both_fp4(cfg_q[0], cfg_q[1]);

endmodule

// File: rtl/mxseq_out.sv
module mxseq_out
    import mxseq_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int PROD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dbg,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] echo,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [PROD_W-1:0] prod0,
    input  logic [PROD_W-1:0] prod1,
    input  logic [BYTE_W-1:0] exc_in,
    input  logic [3:0]        ctl_bits,
    output logic [BYTE_W-1:0] out_byte
);

    localparam int RES_BYTES = ACC_W / BYTE_W;

    logic [ACC_W-1:0]  res_q;
    logic [BYTE_W-1:0] res_byte;
    logic [BYTE_W-1:0] probe;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (en && phase == PH_CALC) begin
            res_q <= acc_in;
        end
    end

    always_comb begin
        res_byte = '0;
        for (int k = 0; k < RES_BYTES; k++) begin
            if (cnt == CNT_W'(k)) res_byte = res_q[BYTE_W*k +: BYTE_W];
        end
    end

    always_comb begin
        unique case (probe_e'(sel))
            PR_STATE: probe = {{(BYTE_W-3){1'b0}}, phase};
            PR_EXC:   probe = exc_in;
            PR_ACC0:  probe = acc_in[0*BYTE_W +: BYTE_W];
            PR_ACC1:  probe = acc_in[1*BYTE_W +: BYTE_W];
            PR_ACC2:  probe = acc_in[2*BYTE_W +: BYTE_W];
            PR_ACC3:  probe = acc_in[3*BYTE_W +: BYTE_W];
            PR_P0L:   probe = prod0[0 +: BYTE_W];
            PR_P0H:   probe = prod0[BYTE_W +: BYTE_W];
            PR_P1L:   probe = prod1[0 +: BYTE_W];
            PR_P1H:   probe = prod1[BYTE_W +: BYTE_W];
            PR_CTRL:  probe = {ctl_bits, 4'b0000};
            default:  probe = '0;
        endcase
    end

    always_comb begin
        unique case (phase)
            PH_CFGA, PH_CFGB, PH_STREAM: out_byte = dbg ? probe : '0;
            PH_FLUSH:                    out_byte = dbg ? echo : '0;
            PH_OUT:                      out_byte = res_byte;
            default:                     out_byte = '0;
        endcase
    end

endmodule

// File: rtl/mxblk_seq.sv
module mxblk_seq
    import mxseq_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int ACC_W  = 32,
    parameter int PROD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [7:0]                bus_a,
    input  logic [7:0]                bus_b,
    input  logic [ACC_W-1:0]          acc_in,
    input  logic [PROD_W-1:0]         prod0,
    input  logic [PROD_W-1:0]         prod1,
    input  logic [7:0]                exc_in,
    output logic [7:0]                out_byte,
    output logic [7:0]                mode_a,
    output logic [7:0]                mode_b,
    output logic [7:0]                scale_a,
    output logic [7:0]                scale_b,
    output logic [2:0]                fmt_a,
    output logic [2:0]                fmt_b,
    output logic [4:0]                bmi_a,
    output logic [4:0]                bmi_b,
    output logic [$clog2(N_ELEM)-1:0] elem_idx,
    output logic                      lane1_en,
    output logic                      acc_clr,
    output logic                      acc_en,
    output logic                      calc_go
);

    localparam int CNT_W     = $clog2(N_ELEM);
    localparam int RES_BYTES = ACC_W / BYTE_W;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pack_now;
    opcfg_t           cfg_a, cfg_b;
    logic             in_stream;

    mxseq_ctrl #(
        .N_ELEM   (N_ELEM),
        .RES_BYTES(RES_BYTES),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .short_req(bus_a[MA_SHORT]),
        .pack_now (pack_now),
        .phase    (phase_q),
        .cnt      (cnt_q)
    );

    mxseq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .phase   (phase_q),
        .bus_a   (bus_a),
        .bus_b   (bus_b),
        .mode_a  (mode_a),
        .mode_b  (mode_b),
        .cfg_a   (cfg_a),
        .cfg_b   (cfg_b),
        .pack_now(pack_now)
    );

    assign in_stream = (phase_q == PH_STREAM);
    assign acc_en    = in_stream && en;
    assign acc_clr   = in_stream && en && (cnt_q == '0);
    assign calc_go   = (phase_q == PH_CALC) && en;
    assign lane1_en  = in_stream && pack_now;
    assign elem_idx  = pack_now ? {cnt_q[CNT_W-2:0], 1'b0} : cnt_q;

    assign scale_a = cfg_a.scale;
    assign scale_b = cfg_b.scale;
    assign fmt_a   = cfg_a.fmt;
    assign fmt_b   = cfg_b.fmt;
    assign bmi_a   = cfg_a.bmi;
    assign bmi_b   = cfg_b.bmi;

    mxseq_out #(
        .ACC_W (ACC_W),
        .PROD_W(PROD_W),
        .CNT_W (CNT_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .phase   (phase_q),
        .cnt     (cnt_q),
        .dbg     (mode_a[MA_DEBUG]),
        .sel     (mode_b[SEL_W-1:0]),
        .echo    (mode_a),
        .acc_in  (acc_in),
        .prod0   (prod0),
        .prod1   (prod1),
        .exc_in  (exc_in),
        .ctl_bits({en, lane1_en, acc_en, acc_clr}),
        .out_byte(out_byte)
    );

endmodule

// File: rtl/mxblk_seq_chk.sv
module mxblk_seq_chk
    import mxseq_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int CNT_W  = $clog2(N_ELEM)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [7:0]       bus_a,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt,
    input logic             pack_now,
    input logic [2:0]       fmt_a,
    input logic [2:0]       fmt_b,
    input logic [CNT_W-1:0] elem_idx,
    input logic             lane1_en,
    input logic             acc_clr,
    input logic             acc_en,
    input logic             calc_go
);

    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(N_ELEM / 2 - 1);

    // R5
    clr_implies_acc_chk: assert property (@(posedge clk) disable iff (rst)
        acc_clr |-> (acc_en && elem_idx == '0));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase) && $stable(cnt)));

    // R9
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(acc_en || acc_clr || calc_go));

    // R2
    short_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_META && en && bus_a[MA_SHORT]) |=> (phase == PH_STREAM && cnt == '0));

    // R3
    lane1_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        lane1_en |-> (fmt_a == FMT_E2M1 && fmt_b == FMT_E2M1));

    // R3
    packed_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STREAM && pack_now && en && cnt == HALF_LAST) |=> phase == PH_FLUSH);

    // R6
    calc_to_out_chk: assert property (@(posedge clk) disable iff (rst)
        calc_go |=> (phase == PH_OUT && cnt == '0));

    // R11
    wrap_to_meta_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OUT && en && cnt == CNT_W'(3)) |=> phase == PH_META);

    // R5
    one_hot_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_en, calc_go}));

endmodule

bind mxblk_seq mxblk_seq_chk #(.N_ELEM(N_ELEM)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bus_a   (bus_a),
    .phase   (phase_q),
    .cnt     (cnt_q),
    .pack_now(pack_now),
    .fmt_a   (fmt_a),
    .fmt_b   (fmt_b),
    .elem_idx(elem_idx),
    .lane1_en(lane1_en),
    .acc_clr (acc_clr),
    .acc_en  (acc_en),
    .calc_go (calc_go)
);

// File: tb/mxblk_seq_tb.sv
module mxblk_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  bus_a = '0, bus_b = '0;
    logic [31:0] acc_in = '0;
    logic [15:0] prod0 = '0, prod1 = '0;
    logic [7:0]  exc_in = '0;
    logic [7:0]  out_byte, mode_a, mode_b, scale_a, scale_b;
    logic [2:0]  fmt_a, fmt_b;
    logic [4:0]  bmi_a, bmi_b, elem_idx;
    logic        lane1_en, acc_clr, acc_en, calc_go;

    always #4 clk = ~clk;

    mxblk_seq u_dut (
        .clk(clk), .rst(rst), .en(en), .bus_a(bus_a), .bus_b(bus_b),
        .acc_in(acc_in), .prod0(prod0), .prod1(prod1), .exc_in(exc_in),
        .out_byte(out_byte), .mode_a(mode_a), .mode_b(mode_b),
        .scale_a(scale_a), .scale_b(scale_b), .fmt_a(fmt_a), .fmt_b(fmt_b),
        .bmi_a(bmi_a), .bmi_b(bmi_b), .elem_idx(elem_idx), .lane1_en(lane1_en),
        .acc_clr(acc_clr), .acc_en(acc_en), .calc_go(calc_go)
    );

    int n_chk = 0;
    int n_err = 0;

    // Reference model state: position in the nominal 0..40 block schedule
    int          pos = 0;
    logic [7:0]  m_ma = '0, m_mb = '0, m_sa = '0, m_sb = '0;
    logic [2:0]  m_fa = '0, m_fb = '0;
    logic [4:0]  m_ba = '0, m_bb = '0;
    logic [31:0] m_res = '0;
    logic [31:0] lf = 32'h1234_5678;
    int          blk_cyc = 0;
    int          dut_acc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int m_len();
        return (m_mb[6] && m_fa == 3'd4 && m_fb == 3'd4) ? 16 : 32;
    endfunction

    function automatic logic [7:0] m_probe(input logic e, input logic l1,
                                           input logic ae, input logic ac);
        int code;
        if (pos == 0) code = 0;
        else if (pos < 3) code = pos;
        else if (pos < 35) code = 3;
        else if (pos == 35) code = 4;
        else if (pos == 36) code = 5;
        else code = 6;
        case (m_mb[3:0])
            4'd0:  return 8'(code);
            4'd1:  return exc_in;
            4'd2:  return acc_in[7:0];
            4'd3:  return acc_in[15:8];
            4'd4:  return acc_in[23:16];
            4'd5:  return acc_in[31:24];
            4'd6:  return prod0[7:0];
            4'd7:  return prod0[15:8];
            4'd8:  return prod1[7:0];
            4'd9:  return prod1[15:8];
            4'd10: return {e, l1, ae, ac, 4'b0000};
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input logic [7:0] a, input logic [7:0] b, input logic e);
        logic       instr, dbg, packed_m, e_ae, e_ac, e_l1, e_calc;
        int         k;
        logic [7:0] e_out;
        string      otag;
        @(negedge clk);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        bus_a = a; bus_b = b; en = e;
        acc_in = lf; prod0 = lf[31:16] ^ 16'h5a3c; prod1 = lf[15:0]; exc_in = lf[23:16];
        #1;
        packed_m = (m_len() == 16);
        instr = (pos >= 3) && (pos < 35);
        k = pos - 3;
        dbg = m_ma[6];
        e_ae = instr && e;
        e_ac = instr && e && (k == 0);
        e_l1 = instr && packed_m;
        e_calc = (pos == 36) && e;
        if (pos >= 37) begin e_out = m_res[8*(pos-37) +: 8]; otag = "R6 result byte"; end
        else if (pos == 35) begin e_out = dbg ? m_ma : 8'h00; otag = dbg ? "R8 echo" : "R7 flush zero"; end
        else if (pos >= 1 && pos <= 34) begin
            e_out = dbg ? m_probe(e, e_l1, e_ae, e_ac) : 8'h00;
            otag = dbg ? "R8 probe" : "R7 zero";
        end else begin e_out = 8'h00; otag = "R7 zero"; end
        chk(otag, out_byte, e_out);
        chk(e ? "R5 acc_en" : "R9 acc_en", acc_en, e_ae);
        chk(e ? "R5 acc_clr" : "R9 acc_clr", acc_clr, e_ac);
        chk(e ? "R6 calc_go" : "R9 calc_go", calc_go, e_calc);
        chk("R3 lane1_en", lane1_en, e_l1);
        if (instr) chk("R3 elem_idx", elem_idx, packed_m ? 32'(2*k) : 32'(k));
        chk("R4 cfg A", {scale_a, fmt_a, bmi_a}, {m_sa, m_fa, m_ba});
        chk("R4 cfg B", {scale_b, fmt_b, bmi_b}, {m_sb, m_fb, m_bb});
        chk("R12 mode", {mode_a, mode_b}, {m_ma, m_mb});
        if (acc_en === 1'b1) dut_acc++;
        if (e) begin
            blk_cyc++;
            if (pos == 0) begin m_ma = a; m_mb = b; pos = a[7] ? 3 : 1; end
            else if (pos == 1) begin m_sa = a; m_fa = b[2:0]; m_ba = b[7:3]; pos = 2; end
            else if (pos == 2) begin m_sb = a; m_fb = b[2:0]; m_bb = b[7:3]; pos = 3; end
            else if (instr) pos = (k == m_len() - 1) ? 35 : pos + 1;
            else if (pos == 36) begin m_res = acc_in; pos = 37; end
            else if (pos == 40) pos = 0;   // R11: straight back to cycle 0
            else pos = pos + 1;
        end
    endtask

    task automatic run_block(input logic [7:0] ma, input logic [7:0] mb,
                             input logic [7:0] sa, input logic [7:0] fa,
                             input logic [7:0] sb, input logic [7:0] fb,
                             input logic gaps, input int exp_cyc, input int exp_len,
                             input string tag);
        blk_cyc = 0;
        dut_acc = 0;
        step(ma, mb, 1'b1);
        while (pos != 0) begin
            if (gaps && lf[2:0] == 3'd0) step(lf[7:0], lf[15:8], 1'b0);
            else if (pos == 1) step(sa, fa, 1'b1);
            else if (pos == 2) step(sb, fb, 1'b1);
            else step(lf[7:0], lf[15:8], 1'b1);
        end
        chk({tag, " block length (R11 wrap)"}, blk_cyc, exp_cyc);
        chk({tag, " accumulate cycles"}, dut_acc, exp_len);
    endtask

    task automatic model_reset();
        pos = 0; m_ma = '0; m_mb = '0; m_sa = '0; m_sb = '0;
        m_fa = '0; m_fb = '0; m_ba = '0; m_bb = '0; m_res = '0;
    endtask

    task automatic reset_checks();
        #1;
        chk("R10 out zero", out_byte, 8'h00);
        chk("R10 cfg clear", {scale_a, scale_b, fmt_a, fmt_b, bmi_a, bmi_b}, '0);
        chk("R10 mode clear", {mode_a, mode_b}, 16'h0000);
        chk("R10 strobes low", {acc_en, acc_clr, calc_go, lane1_en}, 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reset_checks();

        // R1 standard block, debug off, E4M3 / E5M2
        run_block(8'h00, 8'h00, 8'h85, {5'd7, 3'd0}, 8'h7a, {5'd20, 3'd1}, 1'b0, 41, 32, "R1");
        // R2 reuse: config cycles skipped, stored scales kept
        run_block(8'h80, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 39, 32, "R2");
        chk("R2 scale A reused", scale_a, 8'h85);
        chk("R2 format B reused", fmt_b, 3'd1);
        // R8 debug, both FP4 but pack off: full length
        run_block(8'h40, 8'h00, 8'h11, {5'd3, 3'd4}, 8'h22, {5'd9, 3'd4}, 1'b0, 41, 32, "R3 unpacked");
        // R3 pack flag with mismatched formats: full length
        run_block(8'h00, 8'h40, 8'h33, {5'd31, 3'd4}, 8'h44, {5'd0, 3'd2}, 1'b0, 41, 32, "R3 mixed");
        // R3 packed standard block
        run_block(8'h40, 8'h42, 8'h55, {5'd1, 3'd4}, 8'h66, {5'd2, 3'd4}, 1'b0, 25, 16, "R3 packed");
        // R2 + R3: 23-cycle block
        run_block(8'hC0, 8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 23, 16, "R2 R3 fast");
        // R9 enable gaps with junk on the buses
        run_block(8'h40, 8'h06, 8'h99, {5'd12, 3'd5}, 8'hAA, {5'd13, 3'd6}, 1'b1, 41, 32, "R9 gaps");
        run_block(8'h40, 8'h06, 8'h5A, {5'd1, 3'd4}, 8'hA5, {5'd2, 3'd4}, 1'b1, 41, 32, "R9 gaps fp4");
        // R8 sweep of all selectors on fast blocks
        for (int s = 0; s < 12; s++) begin
            run_block(8'hC0, 8'h40 | 8'(s), 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 23, 16, "R8 sweep");
        end
        // R10 reset in mid-block
        step(8'h00, 8'h00, 1'b1);
        step(8'hF0, 8'h0C, 1'b1);
        step(8'h12, 8'h34, 1'b1);
        step(8'h56, 8'h78, 1'b1);
        @(negedge clk); rst = 1'b1; en = 1'b1;
        @(negedge clk); rst = 1'b0; en = 1'b0;
        model_reset();
        reset_checks();
        // R10 reuse after reset sees cleared config
        run_block(8'h80, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 39, 32, "R10 after reset");
        chk("R10 scale after reset", scale_a, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule